// File: doc/BRIEF.md
# Hardware/Software Context Switch Arbiter

This block chooses which hardware context the pipeline runs in each cycle when two sources may ask for a switch. One source is a hardware scheduler, which preempts the running context. The other is a software thread-switch instruction, seen when it is decoded. The selected context changes on the clock edge after a request. No cycle is lost or inserted, so every cycle is charged to exactly one context.

When a hardware preemption and a software switch arrive in the same cycle, the hardware preemption wins. The software target is saved in a return register. A return instruction later ends the hardware preemption, and the saved software switch is carried out in its place. Without such a conflict, the return register holds the context that was preempted, and the return resumes it. Once a return consumes the register, the register is cleared. A later conflict overwrites any earlier saved software target.

Top module: `csw_arbiter`

## Requirements
- R1: After reset, `cur_ctx` is 0, `hw_mode` is 0, `ret_is_sw` is 0 and `ret_target` is 0.
- R2: Every switch takes effect on the clock edge after the request, with no idle cycle. With no accepted event, `cur_ctx` holds its value. Each cycle belongs to exactly one context, whatever mix of events arrives.
- R3: A hardware request (`hw_req`=1) moves `cur_ctx` to `hw_tgt` on the next edge and sets `hw_mode`=1. This holds whether or not `sw_dec` or `ret_dec` is also high. A return that arrives in the same cycle as a hardware request is dropped.
- R4: A hardware request taken while `hw_mode`=0, without `sw_dec`, loads the return register with a plain return: `ret_is_sw`=0 and `ret_target` equal to the preempted `cur_ctx`.
- R5: A hardware request together with `sw_dec` is a conflict. It sets `ret_is_sw`=1 and `ret_target`=`sw_tgt`. A later conflict overwrites that target with its own `sw_tgt`.
- R6: A hardware request taken while `hw_mode`=1, without `sw_dec`, leaves the return register unchanged.
- R7: A return (`ret_dec`=1 with `hw_mode`=1, no `hw_req` and no `sw_dec`) moves `cur_ctx` to `ret_target`. It clears `hw_mode`, and it clears the return register to `ret_is_sw`=0 and `ret_target`=0.
- R8: A return while `hw_mode`=0 has no effect. `cur_ctx`, `hw_mode` and the return register keep their values.
- R9: A software switch without a hardware request moves `cur_ctx` to `sw_tgt` and leaves `hw_mode` and the return register unchanged. If `ret_dec` is high in the same cycle, the switch is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 1 | Hardware preemption request |
| hw_tgt | input | CW | Context requested by the hardware scheduler |
| sw_dec | input | 1 | Software thread-switch instruction decoded |
| sw_tgt | input | CW | Context named by the software switch |
| ret_dec | input | 1 | Return-from-preemption instruction decoded |
| cur_ctx | output | CW | Context selected for execution |
| hw_mode | output | 1 | A hardware preemption is in force |
| ret_is_sw | output | 1 | Return register holds a postponed software switch |
| ret_target | output | CW | Context the next return will select |

## Verification
The hardest case to reach is a conflict that falls inside an existing preemption and is then followed by a return that arrives together with a software switch. To observe that case, the return register must survive a nested preemption and a dropped return before it is consumed. Directed stimulus builds this chain step by step. A long random mix with independent event probabilities then brings about many overlapping cases. A scoreboard model predicts every output after each edge, and it compares the cycles charged to each context against the cycles observed.

// File: rtl/csw_pkg.sv
package csw_pkg;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_HW_PLAIN,
    EV_HW_CONFLICT,
    EV_SW,
    EV_RET,
    EV_RET_DROP
  } csw_ev_e;

  // Priority: hardware first, then software, then return.
  function automatic csw_ev_e csw_classify(input logic hw, input logic sw,
                                           input logic ret, input logic in_hw);
    csw_ev_e ev;
    if (hw && sw)       ev = EV_HW_CONFLICT;
    else if (hw)        ev = EV_HW_PLAIN;
    else if (sw)        ev = EV_SW;
    else if (ret && in_hw) ev = EV_RET;
    else if (ret)       ev = EV_RET_DROP;
    else                ev = EV_IDLE;
    return ev;
  endfunction

endpackage

// File: rtl/csw_event_decode.sv
module csw_event_decode
  import csw_pkg::*;
(
  input  logic hw_req,
  input  logic sw_dec,
  input  logic ret_dec,
  input  logic hw_mode,
  output logic take_hw,
  output logic conflict,
  output logic take_sw,
  output logic take_ret
);

  csw_ev_e ev;

  always_comb begin
    ev       = csw_classify(hw_req, sw_dec, ret_dec, hw_mode);
    take_hw  = (ev == EV_HW_PLAIN) || (ev == EV_HW_CONFLICT);
    conflict = (ev == EV_HW_CONFLICT);
    take_sw  = (ev == EV_SW);
    take_ret = (ev == EV_RET);
  end

endmodule

// File: rtl/csw_return_reg.sv
module csw_return_reg #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_hw,
  input  logic          conflict,
  input  logic          take_ret,
  input  logic          hw_mode,
  input  logic [CW-1:0] cur_ctx,
  input  logic [CW-1:0] sw_tgt,
  output logic          ret_is_sw,
  output logic [CW-1:0] ret_target
);

  logic          load_plain;
  logic          nxt_is_sw;
  logic [CW-1:0] nxt_target;

  // First preemption from normal flow records the preempted context.
  assign load_plain = take_hw && !conflict && !hw_mode;

  always_comb begin
    nxt_is_sw  = ret_is_sw;
    nxt_target = ret_target;
    if (take_ret) begin
      nxt_is_sw  = 1'b0;
      nxt_target = '0;
    end else if (conflict) begin
      nxt_is_sw  = 1'b1;
      nxt_target = sw_tgt;
    end else if (load_plain) begin
      nxt_is_sw  = 1'b0;
      nxt_target = cur_ctx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_is_sw  <= 1'b0;
      ret_target <= '0;
    end else begin
      ret_is_sw  <= nxt_is_sw;
      ret_target <= nxt_target;
    end
  end

endmodule

// File: rtl/csw_ctx_sel.sv
module csw_ctx_sel #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_hw,
  input  logic          take_sw,
  input  logic          take_ret,
  input  logic [CW-1:0] hw_tgt,
  input  logic [CW-1:0] sw_tgt,
  input  logic [CW-1:0] ret_target,
  output logic [CW-1:0] cur_ctx,
  output logic          hw_mode
);

  function automatic logic [CW-1:0] pick_next(
    input logic hw, input logic sw, input logic ret,
    input logic [CW-1:0] ht, input logic [CW-1:0] st,
    input logic [CW-1:0] rt, input logic [CW-1:0] cur);
    if (hw)       return ht;
    else if (sw)  return st;
    else if (ret) return rt;
    return cur;
  endfunction

  logic [CW-1:0] nxt_ctx;
  logic          nxt_mode;

  always_comb begin
    nxt_ctx  = pick_next(take_hw, take_sw, take_ret, hw_tgt, sw_tgt,
                         ret_target, cur_ctx);
    nxt_mode = hw_mode;
    if (take_hw)       nxt_mode = 1'b1;
    else if (take_ret) nxt_mode = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ctx <= '0;
      hw_mode <= 1'b0;
    end else begin
      cur_ctx <= nxt_ctx;
      hw_mode <= nxt_mode;
    end
  end

endmodule

// File: rtl/csw_arbiter.sv
module csw_arbiter #(
  parameter int NUM_CTX = 4,
  localparam int CW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_req,
  input  logic [CW-1:0] hw_tgt,
  input  logic          sw_dec,
  input  logic [CW-1:0] sw_tgt,
  input  logic          ret_dec,
  output logic [CW-1:0] cur_ctx,
  output logic          hw_mode,
  output logic          ret_is_sw,
  output logic [CW-1:0] ret_target
);

  logic take_hw;
  logic conflict;
  logic take_sw;
  logic take_ret;

  csw_event_decode u_dec (
    .hw_req   (hw_req),
    .sw_dec   (sw_dec),
    .ret_dec  (ret_dec),
    .hw_mode  (hw_mode),
    .take_hw  (take_hw),
    .conflict (conflict),
    .take_sw  (take_sw),
    .take_ret (take_ret)
  );

  csw_return_reg #(.CW(CW)) u_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_hw    (take_hw),
    .conflict   (conflict),
    .take_ret   (take_ret),
    .hw_mode    (hw_mode),
    .cur_ctx    (cur_ctx),
    .sw_tgt     (sw_tgt),
    .ret_is_sw  (ret_is_sw),
    .ret_target (ret_target)
  );

  csw_ctx_sel #(.CW(CW)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_hw    (take_hw),
    .take_sw    (take_sw),
    .take_ret   (take_ret),
    .hw_tgt     (hw_tgt),
    .sw_tgt     (sw_tgt),
    .ret_target (ret_target),
    .cur_ctx    (cur_ctx),
    .hw_mode    (hw_mode)
  );

endmodule

// File: rtl/csw_arbiter_chk.sv
module csw_arbiter_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hw_req,
  input logic [CW-1:0] hw_tgt,
  input logic          sw_dec,
  input logic [CW-1:0] sw_tgt,
  input logic          ret_dec,
  input logic [CW-1:0] cur_ctx,
  input logic          hw_mode,
  input logic          ret_is_sw,
  input logic [CW-1:0] ret_target
);

  a_r1_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (cur_ctx == '0 && !hw_mode && !ret_is_sw && ret_target == '0));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_req && !sw_dec && !ret_dec) |=> $stable(cur_ctx) && $stable(hw_mode));

  a_r3_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_req |=> (cur_ctx == $past(hw_tgt)) && hw_mode);

  a_r4_plain_return: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && !sw_dec && !hw_mode) |=> !ret_is_sw && ret_target == $past(cur_ctx));

  a_r5_conflict_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && sw_dec) |=> ret_is_sw && ret_target == $past(sw_tgt));

  a_r6_nested_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req && !sw_dec && hw_mode) |=> $stable(ret_is_sw) && $stable(ret_target));

  a_r7_return_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_dec && hw_mode && !hw_req && !sw_dec) |=>
      cur_ctx == $past(ret_target) && !hw_mode && !ret_is_sw && ret_target == '0);

  a_r8_return_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_dec && !hw_mode && !hw_req && !sw_dec) |=>
      $stable(cur_ctx) && !hw_mode && $stable(ret_is_sw) && $stable(ret_target));

  a_r9_sw_switch: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_dec && !hw_req) |=> cur_ctx == $past(sw_tgt) && $stable(hw_mode)
      && $stable(ret_is_sw) && $stable(ret_target));

endmodule

bind csw_arbiter csw_arbiter_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hw_req     (hw_req),
  .hw_tgt     (hw_tgt),
  .sw_dec     (sw_dec),
  .sw_tgt     (sw_tgt),
  .ret_dec    (ret_dec),
  .cur_ctx    (cur_ctx),
  .hw_mode    (hw_mode),
  .ret_is_sw  (ret_is_sw),
  .ret_target (ret_target)
);

// File: tb/csw_arbiter_bench.sv
module csw_arbiter_bench;

  localparam int NCTX = 4;
  localparam int W = 2;

  typedef struct packed {
    logic [W-1:0] cur;
    logic         hwm;
    logic         rsw;
    logic [W-1:0] rt;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hw_req = 1'b0;
  logic [W-1:0] hw_tgt = '0;
  logic         sw_dec = 1'b0;
  logic [W-1:0] sw_tgt = '0;
  logic         ret_dec = 1'b0;
  logic [W-1:0] cur_ctx;
  logic         hw_mode;
  logic         ret_is_sw;
  logic [W-1:0] ret_target;

  always #2 clk = ~clk;

  csw_arbiter #(.NUM_CTX(NCTX)) u_csw_arbiter (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_tgt(hw_tgt),
    .sw_dec(sw_dec), .sw_tgt(sw_tgt), .ret_dec(ret_dec),
    .cur_ctx(cur_ctx), .hw_mode(hw_mode), .ret_is_sw(ret_is_sw),
    .ret_target(ret_target)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  exp_t  exp_q[$];
  string tag_q[$];
  int    exp_cnt[NCTX];
  int    act_cnt[NCTX];

  // Bench-side model state
  logic [W-1:0] m_cur = '0;
  logic         m_hw = 1'b0;
  logic         m_rsw = 1'b0;
  logic [W-1:0] m_rt = '0;

  task automatic check(input string tag, input exp_t act, input exp_t exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cur/hw/rsw/rt actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
               tag, act.cur, act.hwm, act.rsw, act.rt,
               exp.cur, exp.hwm, exp.rsw, exp.rt);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the predicted outputs.
  task automatic drive(input string tag, input bit h, input int ht,
                       input bit s, input int st, input bit r);
    exp_t e;
    @(negedge clk);
    hw_req = h; hw_tgt = W'(ht); sw_dec = s; sw_tgt = W'(st); ret_dec = r;
    if (h) begin
      if (s) begin m_rsw = 1'b1; m_rt = W'(st); end
      else if (!m_hw) begin m_rsw = 1'b0; m_rt = m_cur; end
      m_cur = W'(ht); m_hw = 1'b1;
    end else if (s) begin
      m_cur = W'(st);
    end else if (r && m_hw) begin
      m_cur = m_rt; m_hw = 1'b0; m_rsw = 1'b0; m_rt = '0;
    end
    e = '{cur: m_cur, hwm: m_hw, rsw: m_rsw, rt: m_rt};
    exp_cnt[m_cur]++;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each edge, away from the edge itself.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        exp_t a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{cur: cur_ctx, hwm: hw_mode, rsw: ret_is_sw, rt: ret_target};
        act_cnt[cur_ctx]++;
        check(t, a, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < NCTX; i++) begin exp_cnt[i] = 0; act_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check("R1", '{cur: cur_ctx, hwm: hw_mode, rsw: ret_is_sw, rt: ret_target},
          '{cur: '0, hwm: 1'b0, rsw: 1'b0, rt: '0});
    @(negedge clk);
    rst_n = 1'b1;

    drive("R2", 0, 0, 0, 0, 0);   // idle keeps ctx 0
    drive("R9", 0, 0, 1, 2, 0);   // sw alone -> 2
    drive("R8", 0, 0, 0, 0, 1);   // return outside preemption dropped
    drive("R4", 1, 3, 0, 0, 0);   // preempt 2 -> 3, plain return to 2
    drive("R6", 1, 1, 0, 0, 0);   // nested preempt keeps register
    drive("R7", 0, 0, 0, 0, 1);   // return to 2, cleared
    drive("R5", 1, 1, 1, 3, 0);   // conflict: hw to 1, sw 3 saved
    drive("R5", 1, 0, 1, 2, 0);   // second conflict overwrites with 2
    drive("R3", 1, 3, 0, 0, 1);   // hw wins over return
    drive("R9", 0, 0, 1, 1, 1);   // sw beats return, register kept
    drive("R7", 0, 0, 0, 0, 1);   // postponed sw 2 runs in place of return
    drive("R8", 0, 0, 0, 0, 1);   // now outside preemption: dropped
    drive("R2", 0, 0, 0, 0, 0);

    for (int k = 0; k < 3000; k++) begin
      drive("R2", ($urandom_range(0, 4) == 0), $urandom_range(0, NCTX - 1),
            ($urandom_range(0, 4) == 0), $urandom_range(0, NCTX - 1),
            ($urandom_range(0, 3) == 0));
    end
    drive("R2", 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #1;

    // R2: cycles charged per context match the model exactly
    for (int i = 0; i < NCTX; i++) begin
      n_chk++;
      if (act_cnt[i] != exp_cnt[i]) begin
        n_bad++;
        $display("FAIL R2 ctx%0d cycle count actual=%0d expected=%0d",
                 i, act_cnt[i], exp_cnt[i]);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule